// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is a slave-side serial audio input port. An outside master drives a bit clock, a frame sync and a serial data line, and the block turns the stream into parallel left and right samples. The three pins are only ever read. They are oversampled on a faster system clock: each passes through a two-flop synchronizer, and the edges of the bit clock are found by comparing the synchronized copy with a delayed one. The system clock must run at four or more times the bit clock rate.

Static configuration inputs choose the framing (I2S, left-justified or a pulse-synchronised DSP framing), the word length, which bit clock edge carries data, and, in DSP framing, whether the first data bit comes one or two active edges after the sync pulse. A finished stereo pair is presented on two 24-bit outputs with a single-cycle strobe. Words shorter than 24 bits sit at the top of the output with zeros below them. A sticky error flag records any frame in which the sync line changed before the configured word had been fully received.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted and right after it, `left_o`, `right_o`, `valid_o` and `short_err_o` are all zero.
- R2: With `fmt_i` = 0 (I2S), the first data bit of a word is the one taken on the second active edge after a sync transition, and the word is the left sample while sync is low and the right sample while sync is high.
- R3: With `fmt_i` = 1 (left-justified), the first data bit is the one taken on the active edge that first sees the new sync level, and the word is left while sync is high and right while sync is low.
- R4: With `fmt_i` = 2 or 3 (DSP), a rise of sync lasting one bit period starts a frame whose left word is followed directly by the right word. `dsp_late_i` = 0 puts the left MSB on the edge that sees sync high, and `dsp_late_i` = 1 puts it on the next active edge.
- R5: `wlen_i` codes 0, 1, 2 and 3 select 8, 16, 20 and 24 bits. Bits arrive MSB first and are placed from bit 23 downward, with every bit below the word set to zero.
- R6: Data bits after the LSB of a word and before the next sync event are ignored, and their presence raises no error.
- R7: `fall_edge_i` = 0 samples data and sync on rising bit clock edges, and `fall_edge_i` = 1 samples them on falling edges.
- R8: `valid_o` is high for exactly one system-clock cycle after the right word's LSB, and only if a left word was completed before it in the same frame. `left_o` and `right_o` change only in the cycle where `valid_o` is high.
- R9: A sync event that arrives while a word is still incomplete sets `short_err_o`, which stays set until reset. The interrupted frame produces no `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock from the master |
| fsync_i | input | 1 | Frame sync from the master |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2/3 DSP |
| wlen_i | input | 2 | Word length: 0=8, 1=16, 2=20, 3=24 bits |
| fall_edge_i | input | 1 | 1 selects the falling bit clock edge for sampling |
| dsp_late_i | input | 1 | DSP framing: 1 delays the MSB by one edge |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new stereo pair |
| short_err_o | output | 1 | Sticky short-frame error |

## Verification
The situation hardest to reach from the ports is a sync change that lands in the middle of a word. A well-formed master never does this, so the bench has to drive a deliberately malformed left-justified stream whose half-frames are shorter than the configured word. The same bench then sends a correct frame, which shows that the error flag stays set while normal delivery resumes. The other difficult cases are the two DSP MSB positions and the falling-edge mode. For those, the bench builds each bit stream by hand and fills every unused slot with ones, so a misplaced capture shows up in the output sample.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_DSP  = 2'd2,
    FMT_DSP2 = 2'd3
  } fmt_e;

  // Word length code to number of bits.
  function automatic logic [4:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    word_bits = 5'd8;
      2'd1:    word_bits = 5'd16;
      2'd2:    word_bits = 5'd20;
      default: word_bits = 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/aud_sync.sv
module aud_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/aud_edge.sv
module aud_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s_i,
  input  logic fall_sel_i,
  output logic strobe_o
);
  logic bclk_d_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d_q <= 1'b0;
    else        bclk_d_q <= bclk_s_i;
  end

  assign rise     = bclk_s_i & ~bclk_d_q;
  assign fall     = ~bclk_s_i & bclk_d_q;
  assign strobe_o = fall_sel_i ? fall : rise;
endmodule

// File: rtl/aud_frame.sv
module aud_frame
  import aud_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_i,
  input  logic       fs_i,
  input  logic [1:0] fmt_i,
  input  logic       dsp_late_i,
  output logic       start_o,
  output logic       chan_o,
  output logic       late_o
);
  logic primed_q, primed_n;
  logic fs_prev_q, fs_prev_n;
  logic is_dsp;

  assign is_dsp = (fmt_i == FMT_DSP) || (fmt_i == FMT_DSP2);

  always_comb begin
    primed_n  = primed_q;
    fs_prev_n = fs_prev_q;
    if (strobe_i) begin
      primed_n  = 1'b1;
      fs_prev_n = fs_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      fs_prev_q <= 1'b0;
    end else begin
      primed_q  <= primed_n;
      fs_prev_q <= fs_prev_n;
    end
  end

  // Start event, channel and MSB delay per framing.
  always_comb begin
    if (is_dsp) begin
      start_o = strobe_i & primed_q & fs_i & ~fs_prev_q;
      chan_o  = 1'b0;
      late_o  = dsp_late_i;
    end else begin
      start_o = strobe_i & primed_q & (fs_i ^ fs_prev_q);
      chan_o  = (fmt_i == FMT_I2S) ? fs_i : ~fs_i;
      late_o  = (fmt_i == FMT_I2S);
    end
  end
endmodule

// File: rtl/aud_deser.sv
module aud_deser
  import aud_rx_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_i,
  input  logic          bit_i,
  input  logic          start_i,
  input  logic          start_chan_i,
  input  logic          start_late_i,
  input  logic          dsp_i,
  input  logic [1:0]    wlen_i,
  output logic [SW-1:0] left_o,
  output logic [SW-1:0] right_o,
  output logic          valid_o,
  output logic          err_o
);
  localparam int PTR_W = $clog2(SW);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(SW - 2);

  logic              busy_q, busy_n, pend_q, pend_n, chan_q, chan_n;
  logic              lok_q, lok_n, valid_q, valid_n, err_q, err_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n, lo;
  logic [SW-1:0]     acc_q, acc_n, lhold_q, lhold_n;
  logic [SW-1:0]     left_q, left_n, right_q, right_n;

  assign lo = PTR_W'(SW - int'(word_bits(wlen_i)));

  always_comb begin
    busy_n = busy_q; pend_n = pend_q; chan_n = chan_q; lok_n = lok_q;
    err_n = err_q; ptr_n = ptr_q; acc_n = acc_q; lhold_n = lhold_q;
    left_n = left_q; right_n = right_q; valid_n = 1'b0;
    if (strobe_i) begin
      if (start_i || pend_q) begin
        if (start_i) begin
          if (busy_q || pend_q) begin
            err_n = 1'b1;
            lok_n = 1'b0;
          end
          chan_n = start_chan_i;
          if (!start_chan_i) lok_n = 1'b0;
        end
        if (start_i && start_late_i) begin
          pend_n = 1'b1;
          busy_n = 1'b0;
        end else begin
          acc_n         = '0;
          acc_n[SW-1]   = bit_i;
          ptr_n         = PTR_TOP;
          busy_n        = 1'b1;
          pend_n        = 1'b0;
        end
      end else if (busy_q) begin
        acc_n[ptr_q] = bit_i;
        if (ptr_q == lo) begin
          busy_n = 1'b0;
          if (!chan_q) begin
            lhold_n = acc_n;
            lok_n   = 1'b1;
            if (dsp_i) begin
              chan_n = 1'b1;
              pend_n = 1'b1;
            end
          end else if (lok_q) begin
            left_n  = lhold_q;
            right_n = acc_n;
            valid_n = 1'b1;
            lok_n   = 1'b0;
          end
        end else begin
          ptr_n = ptr_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; pend_q <= 1'b0; chan_q <= 1'b0; lok_q <= 1'b0;
      valid_q <= 1'b0; err_q <= 1'b0; ptr_q <= '0; acc_q <= '0;
      lhold_q <= '0; left_q <= '0; right_q <= '0;
    end else begin
      busy_q <= busy_n; pend_q <= pend_n; chan_q <= chan_n; lok_q <= lok_n;
      valid_q <= valid_n; err_q <= err_n; ptr_q <= ptr_n; acc_q <= acc_n;
      lhold_q <= lhold_n; left_q <= left_n; right_q <= right_n;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  p_pair_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(left_q) && $stable(right_q)));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && wlen_i == 2'd0) |-> (right_q[SW-9:0] == '0 && left_q[SW-9:0] == '0));
  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (ptr_q >= lo));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                fsync_i,
  input  logic                sdata_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          wlen_i,
  input  logic                fall_edge_i,
  input  logic                dsp_late_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                short_err_o
);
  localparam int PIN_N = 3;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [PIN_N-1:0] pins_s;
  logic             strobe, start, chan, late, is_dsp;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  aud_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d_i({bclk_i, fsync_i, sdata_i}), .q_o(pins_s)
  );

  aud_edge u_edge (
    .clk(clk), .rst_n(rst_int_n), .bclk_s_i(pins_s[2]),
    .fall_sel_i(fall_edge_i), .strobe_o(strobe)
  );

  aud_frame u_frame (
    .clk(clk), .rst_n(rst_int_n), .strobe_i(strobe), .fs_i(pins_s[1]),
    .fmt_i(fmt_i), .dsp_late_i(dsp_late_i),
    .start_o(start), .chan_o(chan), .late_o(late)
  );

  assign is_dsp = (fmt_i == FMT_DSP) || (fmt_i == FMT_DSP2);

  aud_deser #(.SW(SAMPLE_W)) u_deser (
    .clk(clk), .rst_n(rst_int_n), .strobe_i(strobe), .bit_i(pins_s[0]),
    .start_i(start), .start_chan_i(chan), .start_late_i(late),
    .dsp_i(is_dsp), .wlen_i(wlen_i),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .err_o(short_err_o)
  );
endmodule

// File: tb/sim_audio_serial_rx.sv
`timescale 1ns/1ps
module sim_audio_serial_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_i = 1'b0, fsync_i = 1'b0, sdata_i = 1'b0;
  logic [1:0]  fmt_i = 2'd0, wlen_i = 2'd3;
  logic        fall_edge_i = 1'b0, dsp_late_i = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o, short_err_o;

  int nchk = 0, nfail = 0, vcnt = 0;
  logic [23:0] capl = '0, capr = '0;

  always #5 clk = ~clk;

  audio_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fsync_i(fsync_i),
    .sdata_i(sdata_i), .fmt_i(fmt_i), .wlen_i(wlen_i),
    .fall_edge_i(fall_edge_i), .dsp_late_i(dsp_late_i),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .short_err_o(short_err_o)
  );

  always @(negedge clk) if (valid_o) begin
    vcnt++; capl = left_o; capr = right_o;
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bit_cyc(input logic fs, input logic d);
    fsync_i = fs; sdata_i = d; bclk_i = fall_edge_i;
    #40 bclk_i = ~fall_edge_i;
    #40;
  endtask

  task automatic do_reset(input logic fs_idle);
    @(negedge clk);
    rst_n = 1'b0; bclk_i = fall_edge_i; fsync_i = fs_idle; sdata_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    repeat (4) bit_cyc(fs_idle, 1'b1);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic send_i2s(input logic [23:0] l, input logic [23:0] r, input int n, input int slot);
    for (int j = 0; j < slot; j++) bit_cyc(1'b0, (j >= 1 && j <= n) ? l[n-j] : 1'b1);
    for (int j = 0; j < slot; j++) bit_cyc(1'b1, (j >= 1 && j <= n) ? r[n-j] : 1'b1);
  endtask

  task automatic send_lj(input logic [23:0] l, input logic [23:0] r, input int n, input int slot);
    for (int j = 0; j < slot; j++) bit_cyc(1'b1, (j < n) ? l[n-1-j] : 1'b1);
    for (int j = 0; j < slot; j++) bit_cyc(1'b0, (j < n) ? r[n-1-j] : 1'b1);
  endtask

  task automatic send_dsp(input logic [23:0] l, input logic [23:0] r, input int n, input logic late);
    if (late) begin
      bit_cyc(1'b1, 1'b1);
      for (int j = 0; j < n; j++) bit_cyc(1'b0, l[n-1-j]);
    end else begin
      bit_cyc(1'b1, l[n-1]);
      for (int j = 1; j < n; j++) bit_cyc(1'b0, l[n-1-j]);
    end
    for (int j = 0; j < n; j++) bit_cyc(1'b0, r[n-1-j]);
    repeat (5) bit_cyc(1'b0, 1'b1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 left at reset", left_o, 24'h0);
    chk("R1 right at reset", right_o, 24'h0);
    chk("R1 valid at reset", {23'h0, valid_o}, 24'h0);
    chk("R1 error at reset", {23'h0, short_err_o}, 24'h0);
  endtask

  task automatic t_i2s();
    int v0;
    fmt_i = 2'd0; wlen_i = 2'd3; fall_edge_i = 1'b0;
    do_reset(1'b1);
    v0 = vcnt;
    send_i2s(24'hA5C3F1, 24'h5A3C0E, 24, 26);
    settle();
    chk("R2 i2s 24b valid count", 24'(vcnt - v0), 24'd1);
    chk("R2 i2s left", capl, 24'hA5C3F1);
    chk("R2 i2s right", capr, 24'h5A3C0E);
    send_i2s(24'h000001, 24'h800000, 24, 25);
    settle();
    chk("R8 i2s second pair count", 24'(vcnt - v0), 24'd2);
    chk("R2 i2s left lsb only", capl, 24'h000001);
    chk("R2 i2s right msb only", capr, 24'h800000);
  endtask

  task automatic t_lj();
    int v0;
    fmt_i = 2'd1; wlen_i = 2'd1; fall_edge_i = 1'b0;
    do_reset(1'b0);
    v0 = vcnt;
    send_lj(24'h8001, 24'h7FFE, 16, 20);
    settle();
    chk("R3 lj valid count", 24'(vcnt - v0), 24'd1);
    chk("R3 R5 lj left 16b", capl, 24'h800100);
    chk("R3 R5 lj right 16b", capr, 24'h7FFE00);
    chk("R6 no error with idle bits", {23'h0, short_err_o}, 24'h0);
  endtask

  task automatic t_dsp();
    int v0;
    fmt_i = 2'd2; wlen_i = 2'd2; fall_edge_i = 1'b0; dsp_late_i = 1'b0;
    do_reset(1'b0);
    v0 = vcnt;
    send_dsp(24'hFEDCB, 24'h12345, 20, 1'b0);
    settle();
    chk("R4 dsp early count", 24'(vcnt - v0), 24'd1);
    chk("R4 R5 dsp early left 20b", capl, 24'hFEDCB0);
    chk("R4 R5 dsp early right 20b", capr, 24'h123450);
    wlen_i = 2'd0; dsp_late_i = 1'b1;
    do_reset(1'b0);
    v0 = vcnt;
    send_dsp(24'hC3, 24'h3C, 8, 1'b1);
    settle();
    chk("R4 dsp late count", 24'(vcnt - v0), 24'd1);
    chk("R4 R5 dsp late left 8b", capl, 24'hC30000);
    chk("R4 R6 dsp late right 8b", capr, 24'h3C0000);
  endtask

  task automatic t_fall();
    int v0;
    fmt_i = 2'd0; wlen_i = 2'd1; fall_edge_i = 1'b1; dsp_late_i = 1'b0;
    do_reset(1'b1);
    v0 = vcnt;
    send_i2s(24'h1234, 24'hBEEF, 16, 18);
    settle();
    chk("R7 falling edge count", 24'(vcnt - v0), 24'd1);
    chk("R7 falling edge left", capl, 24'h123400);
    chk("R7 falling edge right", capr, 24'hBEEF00);
    fall_edge_i = 1'b0;
  endtask

  task automatic t_short();
    int v0;
    fmt_i = 2'd1; wlen_i = 2'd3; fall_edge_i = 1'b0;
    do_reset(1'b0);
    v0 = vcnt;
    send_lj(24'hFFFFFF, 24'hFFFFFF, 24, 16);
    settle();
    chk("R9 short frame flag", {23'h0, short_err_o}, 24'h1);
    chk("R9 short frame no valid", 24'(vcnt - v0), 24'd0);
    send_lj(24'h13579B, 24'h2468AC, 24, 26);
    settle();
    chk("R9 flag stays set", {23'h0, short_err_o}, 24'h1);
    chk("R9 recovery count", 24'(vcnt - v0), 24'd1);
    chk("R9 recovery left", capl, 24'h13579B);
    chk("R9 recovery right", capr, 24'h2468AC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_i2s();
    t_lj();
    t_dsp();
    t_fall();
    t_short();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule